// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter

This block turns pairs of 24-bit stereo samples into a serial audio stream. It runs on a system clock. In master mode it generates the bit clock and word-select itself by dividing that system clock. The division depends on how fast the system clock runs compared with the sample rate: 256, 384, 512 or 768 times fs. A 256fs or 512fs system clock gives a 64fs bit clock with 32-bit slots. A 384fs or 768fs system clock gives a 48fs bit clock with 24-bit slots. In slave mode an external bit clock and word-select are brought into the system-clock domain, and the block times its output data from their falling edges.

At each frame start the block captures a left and right sample from one of two parallel sources: an acquisition path or a mixer path. It then shifts them out MSB first. The word can be placed in the slot in I2S position, MSB-justified, or LSB-justified at 16, 18, 20 or 24 bits. In slave mode the external bit clock may run at 32, 48, 64, 96 or 128 times fs. The block measures the slot length from the word-select edges and uses it to place LSB-justified words.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ws_o` is 1, `bclk_o` is 0 and `sd_o` is 0.
- R2: With `master_en`=1, `sys_ratio` 0/1/2/3 means a system clock of 256/384/512/768 fs. The bit clock is the system clock divided by 4/8/8/16, so a frame lasts 256/384/512/768 system-clock cycles and each slot holds 32/24/32/24 bit periods.
- R3: In master mode, `ws_o` and `sd_o` change only in the cycle where `bclk_o` falls.
- R4: With `master_en`=0, `bclk_o` stays 0, `ws_o` follows `ws_i`, and slot lengths follow the external clock at 32, 48, 64, 96 and 128 bit periods per frame.
- R5: `fmt`=0 (and the unused codes 6 and 7) selects I2S. The bit period right after a word-select edge is 0, and the 24-bit word starts in the second bit period.
- R6: `fmt`=1 selects MSB-justified: the word MSB is sent in the first bit period of the slot.
- R7: `fmt`=2/3/4/5 selects LSB-justified with N=16/18/20/24. The N most significant sample bits are sent so that the last one falls in the final bit period of the slot.
- R8: If an LSB-justified slot holds fewer than N bit periods, the word starts in the first bit period, and the low-order bits that do not fit are dropped.
- R9: `sd_o` is 0 in every bit period outside the word's window.
- R10: `ws_o`=0 marks the left slot and 1 the right slot. Both samples are captured from the source chosen by `src_sel` (0 acquisition, 1 mixer) at the falling bit-clock edge that starts the left slot. Changes to `src_sel` or to the sample inputs during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1 = generate bit clock and word-select, 0 = follow external ones |
| sys_ratio | input | 2 | System clock to sample rate ratio code (master mode) |
| fmt | input | 3 | Serial format code |
| src_sel | input | 1 | Sample source: 0 acquisition, 1 mixer |
| acq_left | input | 24 | Acquisition path left sample |
| acq_right | input | 24 | Acquisition path right sample |
| mix_left | input | 24 | Mixer path left sample |
| mix_right | input | 24 | Mixer path right sample |
| bclk_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word-select (slave mode) |
| bclk_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Word-select driven with the data |
| sd_o | output | 1 | Serial data |

## Verification
At a falling bit-clock edge that begins a frame, three things happen together: the new samples are captured, the word-select toggles, and, in MSB-justified or truncated LSB-justified formats, the first data bit is sent from the sample being captured in that same cycle. The bench changes both sources and `src_sel` a few bit periods into every frame. A scoreboard of expected sample pairs checks the MSB of each left slot, so it fails if the MSB comes from the previous frame or from the newly changed inputs. The slave runs at 32fs with 24- and 18-bit LSB-justified formats, so the frame start and the truncation rule fall on that same first bit.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int POS_W    = 7;

  typedef logic [2:0] fmt_t;
  localparam fmt_t FMT_I2S   = 3'd0;
  localparam fmt_t FMT_MSBJ  = 3'd1;
  localparam fmt_t FMT_LSB16 = 3'd2;
  localparam fmt_t FMT_LSB18 = 3'd3;
  localparam fmt_t FMT_LSB20 = 3'd4;
  localparam fmt_t FMT_LSB24 = 3'd5;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } sys_ratio_e;

  function automatic logic [POS_W-1:0] lsb_width(input fmt_t f);
    case (f)
      FMT_LSB16: return POS_W'(16);
      FMT_LSB18: return POS_W'(18);
      FMT_LSB20: return POS_W'(20);
      default:   return POS_W'(SAMPLE_W);
    endcase
  endfunction

  function automatic logic is_lsb_fmt(input fmt_t f);
    return (f >= FMT_LSB16) && (f <= FMT_LSB24);
  endfunction

endpackage

// File: rtl/pcm_bclk_div.sv
module pcm_bclk_div #(
  parameter int BASE_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] ratio,
  output logic       bclk,
  output logic       fall_tick
);
  localparam int MAX_HALF = BASE_HALF * 4;
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             wrap;

  always_comb begin
    case (ratio)
      2'd0:    half_m1 = CNT_W'(BASE_HALF - 1);
      2'd1:    half_m1 = CNT_W'(BASE_HALF * 2 - 1);
      2'd2:    half_m1 = CNT_W'(BASE_HALF * 2 - 1);
      default: half_m1 = CNT_W'(BASE_HALF * 4 - 1);
    endcase
    wrap      = (cnt_q >= half_m1);
    fall_tick = en && !rst && wrap && bclk;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      bclk  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      bclk  <= ~bclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic ws_in,
  output logic fall_tick,
  output logic ws_lvl
);
  logic [STAGES-1:0] bclk_sh;
  logic [STAGES-1:0] ws_sh;
  logic              bclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_sh   <= '1;
      ws_sh     <= '1;
      bclk_prev <= 1'b1;
    end else begin
      bclk_sh   <= {bclk_sh[STAGES-2:0], bclk_in};
      ws_sh     <= {ws_sh[STAGES-2:0], ws_in};
      bclk_prev <= bclk_sh[STAGES-1];
    end
  end

  assign fall_tick = bclk_prev & ~bclk_sh[STAGES-1];
  assign ws_lvl    = ws_sh[STAGES-1];
endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
  import pcm_tx_pkg::*;
#(
  parameter int SW       = SAMPLE_W,
  parameter int PW       = POS_W,
  parameter int INIT_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          master,
  input  logic          ws_ext,
  input  logic [PW-1:0] master_len,
  input  fmt_t          fmt,
  input  logic          src_sel,
  input  logic [SW-1:0] acq_l,
  input  logic [SW-1:0] acq_r,
  input  logic [SW-1:0] mix_l,
  input  logic [SW-1:0] mix_r,
  output logic          ws_o,
  output logic          sd_o
);
  localparam logic [PW-1:0] POS_MAX = '1;
  localparam int            IDX_W   = $clog2(SW);

  logic          chan_q;
  logic [PW-1:0] pos_q, meas_q;
  logic [SW-1:0] left_q, right_q;

  logic          boundary, nchan, frame_go, len_ok, bit_v;
  logic [PW-1:0] npos, slot_len, first, nbits, k;
  logic [SW-1:0] sel_l, sel_r, word;

  always_comb begin
    len_ok   = (pos_q != POS_MAX);
    boundary = master ? (pos_q >= master_len - 1'b1) : (ws_ext != chan_q);
    nchan    = chan_q ^ boundary;
    npos     = boundary ? '0 : (len_ok ? pos_q + 1'b1 : pos_q);
    frame_go = boundary & ~nchan;
    sel_l    = src_sel ? mix_l : acq_l;
    sel_r    = src_sel ? mix_r : acq_r;
    word     = nchan ? right_q : (frame_go ? sel_l : left_q);

    if (master)                  slot_len = master_len;
    else if (boundary && len_ok) slot_len = pos_q + 1'b1;
    else                         slot_len = meas_q;

    if (fmt == FMT_MSBJ) begin
      first = '0;
      nbits = PW'(SW);
    end else if (is_lsb_fmt(fmt)) begin
      nbits = lsb_width(fmt);
      first = (slot_len > nbits) ? slot_len - nbits : '0;
    end else begin
      first = PW'(1);
      nbits = PW'(SW);
    end

    k     = npos - first;
    bit_v = 1'b0;
    if (npos >= first && k < nbits)
      bit_v = word[IDX_W'(SW - 1) - k[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q  <= 1'b1;
      pos_q   <= POS_MAX;
      meas_q  <= PW'(INIT_LEN);
      left_q  <= '0;
      right_q <= '0;
      sd_o    <= 1'b0;
    end else if (tick) begin
      chan_q <= nchan;
      pos_q  <= npos;
      sd_o   <= bit_v;
      if (!master && boundary && len_ok)
        meas_q <= pos_q + 1'b1;
      if (frame_go) begin
        left_q  <= sel_l;
        right_q <= sel_r;
      end
    end
  end

  assign ws_o = chan_q;
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BASE_HALF   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_en,
  input  logic [1:0]          sys_ratio,
  input  logic [2:0]          fmt,
  input  logic                src_sel,
  input  logic [SAMPLE_W-1:0] acq_left,
  input  logic [SAMPLE_W-1:0] acq_right,
  input  logic [SAMPLE_W-1:0] mix_left,
  input  logic [SAMPLE_W-1:0] mix_right,
  input  logic                bclk_i,
  input  logic                ws_i,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);
  logic             m_fall, s_fall, s_ws, tick;
  logic [POS_W-1:0] master_len;
  sys_ratio_e       ratio_e;

  assign ratio_e    = sys_ratio_e'(sys_ratio);
  assign master_len = (ratio_e == RATIO_384 || ratio_e == RATIO_768) ? POS_W'(24) : POS_W'(32);
  assign tick       = master_en ? m_fall : s_fall;

  pcm_bclk_div #(.BASE_HALF(BASE_HALF)) u_div (
    .clk       (clk),
    .rst       (rst),
    .en        (master_en),
    .ratio     (sys_ratio),
    .bclk      (bclk_o),
    .fall_tick (m_fall)
  );

  pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .bclk_in   (bclk_i),
    .ws_in     (ws_i),
    .fall_tick (s_fall),
    .ws_lvl    (s_ws)
  );

  pcm_framer u_framer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .master     (master_en),
    .ws_ext     (s_ws),
    .master_len (master_len),
    .fmt        (fmt),
    .src_sel    (src_sel),
    .acq_l      (acq_left),
    .acq_r      (acq_right),
    .mix_l      (mix_left),
    .mix_r      (mix_right),
    .ws_o       (ws_o),
    .sd_o       (sd_o)
  );
endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk (
  input logic        clk,
  input logic        rst,
  input logic        master_en,
  input logic [1:0]  sys_ratio,
  input logic [2:0]  fmt,
  input logic        bclk_o,
  input logic        ws_o,
  input logic        sd_o
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ws_o && !bclk_o && !sd_o));

  // R3
  a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
    (master_en && !$stable(ws_o)) |-> $fell(bclk_o));

  // R3
  a_r3_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
    (master_en && !$stable(sd_o)) |-> $fell(bclk_o));

  // R4
  a_r4_slave_bclk_low: assert property (@(posedge clk) disable iff (rst)
    (!master_en && $past(!master_en)) |-> !bclk_o);

  // R5: first bit after a word-select edge is zero in I2S
  a_r5_i2s_lead_zero: assert property (@(posedge clk) disable iff (rst)
    (master_en && (fmt == 3'd0 || fmt >= 3'd6) && !$stable(ws_o)) |-> !sd_o);

  // R9: 24-bit LSB-justified word in a 32-bit slot leaves the first bit empty
  a_r9_lsb_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (master_en && fmt == 3'd5 && !sys_ratio[0] && !$stable(ws_o)) |-> !sd_o);
endmodule

bind pcm_serial_tx pcm_serial_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .master_en (master_en),
  .sys_ratio (sys_ratio),
  .fmt       (fmt),
  .bclk_o    (bclk_o),
  .ws_o      (ws_o),
  .sd_o      (sd_o)
);

// File: tb/pcm_serial_tx_tb.sv
module pcm_serial_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_en = 1'b1;
  logic [1:0]  sys_ratio = 2'd0;
  logic [2:0]  fmt = 3'd0;
  logic        src_sel = 1'b0;
  logic [23:0] acq_left = '0, acq_right = '0, mix_left = '0, mix_right = '0;
  logic        bclk_i = 1'b1, ws_i = 1'b1;
  logic        bclk_o, ws_o, sd_o;

  always #10 clk = ~clk;

  pcm_serial_tx u_dut (
    .clk(clk), .rst(rst), .master_en(master_en), .sys_ratio(sys_ratio),
    .fmt(fmt), .src_sel(src_sel), .acq_left(acq_left), .acq_right(acq_right),
    .mix_left(mix_left), .mix_right(mix_right), .bclk_i(bclk_i), .ws_i(ws_i),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  typedef struct { logic [23:0] l; logic [23:0] r; } pair_t;
  pair_t q[$];

  int checks = 0, errors = 0;
  event ev_frame;
  bit mon_on = 0, slave_en = 0;
  int slave_bpf = 64, exp_slot = 32, exp_frame_cyc = 256;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [2:0] f, input int s,
                                   input logic [23:0] w, input int p);
    int first, nb, k;
    nb = (f == 3'd2) ? 16 : (f == 3'd3) ? 18 : (f == 3'd4) ? 20 : 24;
    if (f == 3'd1) first = 0;
    else if (f >= 3'd2 && f <= 3'd5) first = (s > nb) ? s - nb : 0;
    else first = 1;
    k = p - first;
    return (k >= 0 && k < nb) ? w[23-k] : 1'b0;
  endfunction

  function automatic string slot_req(input logic [2:0] f, input int s);
    int nb;
    nb = (f == 3'd2) ? 16 : (f == 3'd3) ? 18 : (f == 3'd4) ? 20 : 24;
    if (f == 3'd1) return "R6 R9 R10";
    if (f >= 3'd2 && f <= 3'd5) return (s < nb) ? "R8 R9 R10" : "R7 R9 R10";
    return "R5 R9 R10";
  endfunction

  // monitor state
  bit pb, pws, pbm, pwo, pso, r3_bad, r4_bad;
  int lcnt, rcnt, fidx, cyc = 0, start_cyc;
  logic [127:0] lb, rb;

  task automatic cmp_slot(input string side, input logic [127:0] got, input int n,
                          input logic [23:0] w);
    longint a = 0, e = 0;
    bit ok = 1;
    chk(n == exp_slot, master_en ? "R2" : "R4", {side, " slot length"}, n, exp_slot);
    for (int p = 0; p < exp_slot && p < 64; p++) begin
      a = (a << 1) | longint'(got[p]);
      e = (e << 1) | longint'(exp_bit(fmt, exp_slot, w, p));
      if (got[p] !== exp_bit(fmt, exp_slot, w, p)) ok = 0;
    end
    chk(ok, slot_req(fmt, exp_slot), {side, " slot bits"}, a, e);
  endtask

  task automatic finish_frame(input int fc);
    pair_t e;
    e = q.pop_front();
    if (fidx >= 1) begin
      cmp_slot("left", lb, lcnt, e.l);
      cmp_slot("right", rb, rcnt, e.r);
      if (master_en) begin
        chk(fc == exp_frame_cyc, "R2", "frame cycles", fc, exp_frame_cyc);
        chk(!r3_bad, "R3", "ws/sd change away from bclk fall", r3_bad, 0);
      end else begin
        chk(!r4_bad, "R4", "ws_o/bclk_o follow in slave", r4_bad, 0);
      end
    end
    r3_bad = 0;
    r4_bad = 0;
  endtask

  always @(negedge clk) begin
    bit ob, ows;
    cyc++;
    if (mon_on) begin
      if (master_en && (ws_o !== pwo || sd_o !== pso) && !(pbm && !bclk_o)) r3_bad = 1;
      if (!master_en && bclk_o !== 1'b0) r4_bad = 1;
      ob  = master_en ? bclk_o : bclk_i;
      ows = master_en ? ws_o : ws_i;
      if (ob && !pb) begin
        if (!master_en && ws_o !== ws_i) r4_bad = 1;
        if (!ows && pws) begin
          if (fidx >= 0) finish_frame(cyc - start_cyc);
          fidx++;
          lcnt = 0;
          start_cyc = cyc;
          -> ev_frame;
        end else if (ows && !pws) begin
          rcnt = 0;
        end
        if (!ows) begin
          if (lcnt < 128) lb[lcnt] = sd_o;
          lcnt++;
        end else begin
          if (rcnt < 128) rb[rcnt] = sd_o;
          rcnt++;
        end
        pws = ows;
      end
      pb = ob;
    end
    pbm = bclk_o;
    pwo = ws_o;
    pso = sd_o;
  end

  // external clock source for slave mode
  initial begin
    forever begin
      @(posedge clk);
      if (slave_en) begin
        for (int b = 0; b < slave_bpf && slave_en; b++) begin
          #5 bclk_i = 1'b0;
          ws_i = (b >= slave_bpf / 2);
          repeat (8) @(posedge clk);
          #5 bclk_i = 1'b1;
          repeat (7) @(posedge clk);
        end
      end else begin
        #5 bclk_i = 1'b1;
        ws_i = 1'b1;
      end
    end
  end

  task automatic new_values();
    pair_t e;
    acq_left  = 24'($urandom);
    acq_right = 24'($urandom);
    mix_left  = 24'($urandom);
    mix_right = 24'($urandom);
    src_sel   = 1'($urandom);
    e.l = src_sel ? mix_left : acq_left;
    e.r = src_sel ? mix_right : acq_right;
    q.push_back(e);
  endtask

  task automatic run_phase(input bit m, input logic [1:0] r, input logic [2:0] f,
                           input int bpf);
    mon_on   = 0;
    slave_en = 0;
    @(posedge clk);
    #2 rst = 1'b1;
    master_en = m;
    sys_ratio = r;
    fmt = f;
    slave_bpf = bpf;
    exp_slot = m ? (r[0] ? 24 : 32) : bpf / 2;
    exp_frame_cyc = (r == 2'd0) ? 256 : (r == 2'd1) ? 384 : (r == 2'd2) ? 512 : 768;
    repeat (4) @(posedge clk);
    #3;
    chk(ws_o === 1'b1 && bclk_o === 1'b0 && sd_o === 1'b0, "R1", "reset outputs",
        {ws_o, bclk_o, sd_o}, 3'b100);
    q.delete();
    new_values();
    fidx = -1;
    pb = 1;
    pws = 1;
    r3_bad = 0;
    r4_bad = 0;
    @(posedge clk);
    #2 rst = 1'b0;
    mon_on = 1;
    slave_en = !m;
    // a few bit periods into each frame, change both sources and the select
    repeat (6) begin
      @(ev_frame);
      new_values();
    end
    mon_on = 0;
    slave_en = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    run_phase(1'b1, 2'd0, 3'd0, 64);  // R2 R5 256fs I2S
    run_phase(1'b1, 2'd1, 3'd1, 64);  // R2 R6 384fs MSB-justified
    run_phase(1'b1, 2'd2, 3'd2, 64);  // R2 R7 512fs LSB16
    run_phase(1'b1, 2'd3, 3'd5, 64);  // R2 R7 768fs LSB24 exact fit
    run_phase(1'b1, 2'd0, 3'd4, 64);  // R7 R9 LSB20 padding
    run_phase(1'b1, 2'd1, 3'd7, 64);  // R5 unused code acts as I2S
    run_phase(1'b0, 2'd0, 3'd5, 32);  // R4 R8 slave 32fs LSB24
    run_phase(1'b0, 2'd0, 3'd3, 32);  // R8 slave 32fs LSB18
    run_phase(1'b0, 2'd0, 3'd0, 48);  // R4 R5 slave 48fs I2S
    run_phase(1'b0, 2'd0, 3'd1, 64);  // R4 R6 slave 64fs
    run_phase(1'b0, 2'd0, 3'd3, 96);  // R4 R7 slave 96fs LSB18
    run_phase(1'b0, 2'd0, 3'd2, 128); // R4 R7 slave 128fs LSB16
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule